// File: doc/BRIEF.md
# Shared interrupt source controller

This block takes a parameterised group of external interrupt lines and turns each one into a pending condition. Each line has its own conditioning setting. A line can be level or edge sensitive, and active-high or active-low. In edge mode it can optionally capture both transitions. Software reaches the block through a simple 32-bit register port, on which a write takes effect at the next clock edge and a read returns data in the same cycle.

Each line has an enable bit. The enable bits change only through two write-only registers: one sets bits where a 1 is written, the other clears them. A read-only register shows the enable state, and another read-only register shows the pending state. A command register sets or clears a line's edge latch by line number, so software can inject an interrupt or acknowledge one.

Each line also has a routing word. It holds a route flag and a 6-bit pin index. An output pin goes high when at least one line is enabled, pending, routed and pointed at that pin. The block also gives a vector number, which is the highest active pin index plus one.

Top module: `irq_router`

Register map (byte addresses):

| Address | Access | Contents |
|---|---|---|
| 0x040 + 4w | read/write | polarity, word w |
| 0x080 + 4w | read/write | trigger mode, word w |
| 0x0C0 + 4w | read/write | dual-edge enable, word w |
| 0x100 + 4w | write-only | enable set, word w |
| 0x140 + 4w | write-only | enable clear, word w |
| 0x180 + 4w | read-only | enable readback, word w |
| 0x1C0 + 4w | read-only | pending, word w |
| 0x200 | write-only | edge latch command |
| 0x400 + 4n | read/write | routing word for line n |

## Requirements
- R1: After reset, the polarity, trigger, dual-edge, enable and routing registers all read 0. With every input held high, the pending words read 0, pin_out is 0 and vec_out is 0.
- R2: A line in level mode (trigger bit 0) shows its live input in the pending register. With polarity bit 1 it is pending while the input is high; with polarity bit 0 it is pending while the input is low.
- R3: A line in edge mode (trigger bit 1) with its dual-edge bit at 0 sets its latch on a rising input when its polarity bit is 1, and on a falling input when its polarity bit is 0. The opposite transition does not set the latch.
- R4: In edge mode, a dual-edge bit of 1 makes both rising and falling transitions set the latch. In level mode the dual-edge bit has no effect on pending.
- R5: An edge latch stays set after the input returns to its idle level. It clears only when a command write to 0x200 with bit 31 at 0 names that line.
- R6: A command write to 0x200 with bit 31 at 1 sets the latch of the edge-mode line whose number is in bits 7:0. A number at or above NUM_LINES changes nothing. A line in level mode ignores the set command.
- R7: Writing to the enable-set register sets the enable bits where the data has 1s. Writing to the enable-clear register clears the enable bits where the data has 1s. Bits written as 0 are left unchanged, and the enable readback shows 1 for an enabled line.
- R8: The enable-set and enable-clear addresses read as 0.
- R9: Line n appears in word n/32 of every per-line register, at bit n%32.
- R10: A routing word keeps its route flag in bit 31 and its pin index in bits 5:0; all other bits read back as 0. Pin p of pin_out goes high one clock after at least one line is pending, enabled, has its route flag at 1 and has pin index p. A line with its route flag at 0, or with its enable bit at 0, drives no pin.
- R11: vec_out equals the highest set bit index of pin_out plus one, and is 0 when pin_out is 0.
- R12: A routing pin index at or above NUM_PINS drives no pin.
- R13: The pending register reports lines regardless of their enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | External interrupt lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| pin_out | output | NUM_PINS | Registered interrupt pin outputs |
| vec_out | output | $clog2(NUM_PINS+1) | Highest active pin index plus one, 0 when no pin is active |

## Verification
The bench checks that a latched edge survives the input returning to idle. A design that cleared the latch when the input went idle would lose that interrupt before software could see it.

Several checks guard against decoding errors:
- The bench programs the opposite edge under each polarity. A decoder with swapped senses would latch on the wrong transition.
- It sets the dual-edge bit on a level-mode line. A design that leaked that bit into level mode would change the pending state.
- It issues commands with a line number out of range. A design that truncated the number would hit some other line.
- It issues a set command aimed at a level-mode line, which must have no effect.

Routing is checked with two pins active together, then with the route flag off, then with a pin index beyond the last pin. A wrong priority encoder would give the wrong vector number. A decoder that did not check the index range would raise a wrong or aliased pin.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NUM_LINES = 64,
  parameter int NUM_PINS  = 6,
  localparam int VEC_W    = $clog2(NUM_PINS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 reg_we,
  input  logic [11:0]          reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic [VEC_W-1:0]     vec_out
);
  localparam int NW = NUM_LINES / 32;
  localparam logic [3:0] G_POL  = 4'd1;
  localparam logic [3:0] G_TRIG = 4'd2;
  localparam logic [3:0] G_DUAL = 4'd3;
  localparam logic [3:0] G_MSET = 4'd4;
  localparam logic [3:0] G_MCLR = 4'd5;
  localparam logic [3:0] G_MASK = 4'd6;
  localparam logic [3:0] G_PEND = 4'd7;
  localparam logic [3:0] G_EDGE = 4'd8;

  logic [NUM_LINES-1:0] pol_q, trig_q, dual_q, mask_q, latch_q, in_q, rt_en_q;
  logic [5:0]           rt_pin_q [NUM_LINES];
  logic [NUM_PINS-1:0]  pin_q, pin_nxt;
  logic [NUM_LINES-1:0] cmd_hit;

  wire       grp_sel = reg_addr[11:10] == 2'b00;
  wire       rt_sel  = reg_addr[11:10] == 2'b01;
  wire [3:0] grp     = reg_addr[9:6];
  wire [3:0] widx    = reg_addr[5:2];
  wire [7:0] rt_idx  = reg_addr[9:2];
  wire       cmd_we  = reg_we && grp_sel && grp == G_EDGE && widx == 4'd0;

  wire [NUM_LINES-1:0] live  = ~(irq_in ^ pol_q);
  wire [NUM_LINES-1:0] rise  = irq_in & ~in_q;
  wire [NUM_LINES-1:0] fall  = ~irq_in & in_q;
  wire [NUM_LINES-1:0] det   = trig_q & ((dual_q & (rise | fall)) |
                                         (~dual_q & ((pol_q & rise) | (~pol_q & fall))));
  wire [NUM_LINES-1:0] set_v = cmd_hit & {NUM_LINES{reg_wdata[31]}};
  wire [NUM_LINES-1:0] clr_v = cmd_hit & {NUM_LINES{~reg_wdata[31]}};
  wire [NUM_LINES-1:0] latch_nxt = ((latch_q & ~clr_v) | set_v | det) & trig_q;
  wire [NUM_LINES-1:0] pend  = (trig_q & latch_q) | (~trig_q & live);
  wire [NUM_LINES-1:0] armed = pend & mask_q & rt_en_q;

  always_comb begin
    for (int n = 0; n < NUM_LINES; n++)
      cmd_hit[n] = cmd_we && reg_wdata[7:0] == 8'(n);
  end

  always_comb begin
    pin_nxt = '0;
    for (int p = 0; p < NUM_PINS; p++)
      for (int n = 0; n < NUM_LINES; n++)
        if (armed[n] && rt_pin_q[n] == 6'(p)) pin_nxt[p] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q   <= '0;
      trig_q  <= '0;
      dual_q  <= '0;
      mask_q  <= '0;
      latch_q <= '0;
      in_q    <= '0;
      rt_en_q <= '0;
      pin_q   <= '0;
      for (int n = 0; n < NUM_LINES; n++) rt_pin_q[n] <= '0;
    end else begin
      in_q    <= irq_in;
      latch_q <= latch_nxt;
      pin_q   <= pin_nxt;
      for (int w = 0; w < NW; w++) begin
        if (reg_we && grp_sel && widx == 4'(w)) begin
          case (grp)
            G_POL:   pol_q[w*32 +: 32]  <= reg_wdata;
            G_TRIG:  trig_q[w*32 +: 32] <= reg_wdata;
            G_DUAL:  dual_q[w*32 +: 32] <= reg_wdata;
            G_MSET:  mask_q[w*32 +: 32] <= mask_q[w*32 +: 32] | reg_wdata;
            G_MCLR:  mask_q[w*32 +: 32] <= mask_q[w*32 +: 32] & ~reg_wdata;
            default: ;
          endcase
        end
      end
      for (int n = 0; n < NUM_LINES; n++) begin
        if (reg_we && rt_sel && rt_idx == 8'(n)) begin
          rt_en_q[n]  <= reg_wdata[31];
          rt_pin_q[n] <= reg_wdata[5:0];
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (rt_sel) begin
      for (int n = 0; n < NUM_LINES; n++)
        if (rt_idx == 8'(n)) reg_rdata = {rt_en_q[n], 25'd0, rt_pin_q[n]};
    end else if (grp_sel) begin
      for (int w = 0; w < NW; w++) begin
        if (widx == 4'(w)) begin
          case (grp)
            G_POL:   reg_rdata = pol_q[w*32 +: 32];
            G_TRIG:  reg_rdata = trig_q[w*32 +: 32];
            G_DUAL:  reg_rdata = dual_q[w*32 +: 32];
            G_MASK:  reg_rdata = mask_q[w*32 +: 32];
            G_PEND:  reg_rdata = pend[w*32 +: 32];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    vec_out = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (pin_q[p]) vec_out = VEC_W'(p + 1);
  end

  assign pin_out = pin_q;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_LINES = 64,
  parameter int NUM_PINS  = 6,
  localparam int VEC_W    = $clog2(NUM_PINS + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] latch_q,
  input logic [NUM_PINS-1:0]  pin_out,
  input logic [VEC_W-1:0]     vec_out
);
  localparam logic [NUM_PINS-1:0] ONE = {{(NUM_PINS-1){1'b0}}, 1'b1};

  assert_mask_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(mask_q));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ((~latch_q & $past(latch_q)) == '0));

  assert_vec_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out == '0) |-> (vec_out == '0));

  assert_vec_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_out != '0) |-> ((pin_out >> (vec_out - VEC_W'(1))) == ONE));

  assert_pin_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out != '0) |-> ($past(mask_q) != '0));
endmodule

bind irq_router irq_router_chk #(.NUM_LINES(NUM_LINES), .NUM_PINS(NUM_PINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .mask_q(mask_q),
  .latch_q(latch_q), .pin_out(pin_out), .vec_out(vec_out)
);

// File: tb/irq_router_tb.sv
module irq_router_tb_top;
  localparam int NL = 64;
  localparam int NP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_in = '1;
  logic          reg_we = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pin_out;
  logic [2:0]    vec_out;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_router #(.NUM_LINES(NL), .NUM_PINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_out(pin_out), .vec_out(vec_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    reg_addr = a;
    #1 d = reg_rdata;
    chk(d === exp, tag, d, exp);
  endtask

  task automatic pinchk(input logic [NP-1:0] ep, input logic [2:0] ev, input string tag);
    chk(pin_out === ep, {tag, " pins"}, 32'(pin_out), 32'(ep));
    chk(vec_out === ev, {tag, " vec"}, 32'(vec_out), 32'(ev));
  endtask

  task automatic t_reset;
    for (int w = 0; w < 2; w++) begin
      rdchk(12'h040 + 12'(4*w), 0, "R1 pol");
      rdchk(12'h080 + 12'(4*w), 0, "R1 trig");
      rdchk(12'h0C0 + 12'(4*w), 0, "R1 dual");
      rdchk(12'h180 + 12'(4*w), 0, "R1 mask");
      rdchk(12'h1C0 + 12'(4*w), 0, "R1 pend");
    end
    rdchk(12'h4A0, 0, "R1 route");
    pinchk('0, 0, "R1");
  endtask

  task automatic t_level;
    wr(12'h040, 32'h8);
    rdchk(12'h1C0, 32'h8, "R2 active-high level pending");
    irq_in[3] = 1'b0; tick(1);
    rdchk(12'h1C0, 32'h0, "R2 active-high level idle");
    irq_in[5] = 1'b0; tick(1);
    rdchk(12'h1C0, 32'h20, "R13 active-low level pending while disabled");
    irq_in[5] = 1'b1; irq_in[3] = 1'b1; tick(1);
  endtask

  task automatic t_edge;
    wr(12'h044, 32'h100);
    wr(12'h084, 32'h100);
    irq_in[40] = 1'b0; tick(2);
    rdchk(12'h1C4, 0, "R3 falling ignored under rising polarity");
    irq_in[40] = 1'b1; tick(1);
    rdchk(12'h1C4, 32'h100, "R3 R9 rising latched word1 bit8");
    irq_in[40] = 1'b0; tick(2);
    rdchk(12'h1C4, 32'h100, "R5 latch held after input idles");
    wr(12'h200, 32'd40);
    rdchk(12'h1C4, 0, "R5 clear command");
    wr(12'h044, 32'h0);
    irq_in[40] = 1'b1; tick(2);
    rdchk(12'h1C4, 0, "R3 rising ignored under falling polarity");
    irq_in[40] = 1'b0; tick(1);
    rdchk(12'h1C4, 32'h100, "R3 falling latched");
    wr(12'h200, 32'd40);
  endtask

  task automatic t_dual;
    wr(12'h0C4, 32'h100);
    irq_in[40] = 1'b1; tick(1);
    rdchk(12'h1C4, 32'h100, "R4 dual rising");
    wr(12'h200, 32'd40);
    irq_in[40] = 1'b0; tick(1);
    rdchk(12'h1C4, 32'h100, "R4 dual falling");
    wr(12'h200, 32'd40);
    wr(12'h0C4, 32'h0);
    irq_in[40] = 1'b1; tick(1);
    wr(12'h0C0, 32'h8);
    irq_in[3] = 1'b0; tick(1);
    rdchk(12'h1C0, 32'h0, "R4 dual ignored in level mode idle");
    irq_in[3] = 1'b1; tick(1);
    rdchk(12'h1C0, 32'h8, "R4 dual ignored in level mode active");
    wr(12'h0C0, 32'h0);
  endtask

  task automatic t_inject;
    wr(12'h084, 32'h300);
    wr(12'h200, 32'h8000_0029);
    rdchk(12'h1C4, 32'h200, "R6 inject line 41");
    wr(12'h200, 32'h8000_0064);
    rdchk(12'h1C4, 32'h200, "R6 out-of-range number word1");
    rdchk(12'h1C0, 32'h8, "R6 out-of-range number word0");
    irq_in[3] = 1'b0; tick(1);
    wr(12'h200, 32'h8000_0003);
    rdchk(12'h1C0, 32'h0, "R6 set ignored on level line");
  endtask

  task automatic t_mask;
    wr(12'h100, 32'hF0);
    rdchk(12'h180, 32'hF0, "R7 set");
    wr(12'h100, 32'h3);
    rdchk(12'h180, 32'hF3, "R7 set keeps others");
    wr(12'h140, 32'h30);
    rdchk(12'h180, 32'hC3, "R7 clear");
    wr(12'h140, 32'h0);
    rdchk(12'h180, 32'hC3, "R7 zero clear no effect");
    rdchk(12'h100, 0, "R8 set reads 0");
    rdchk(12'h140, 0, "R8 clear reads 0");
    wr(12'h104, 32'h100);
    rdchk(12'h184, 32'h100, "R9 word1 mask");
    rdchk(12'h180, 32'hC3, "R9 word0 untouched");
  endtask

  task automatic t_route;
    wr(12'h104, 32'h200);
    wr(12'h200, 32'h8000_0028);
    wr(12'h4A0, 32'h8000_0002);
    tick(2);
    pinchk(6'b000100, 3'd3, "R10 single route");
    wr(12'h4A4, 32'h8000_0004);
    tick(2);
    pinchk(6'b010100, 3'd5, "R11 highest pin wins");
    wr(12'h144, 32'h200);
    tick(2);
    pinchk(6'b000100, 3'd3, "R10 disabled line drops");
    wr(12'h4A0, 32'h0000_0002);
    tick(2);
    pinchk('0, 3'd0, "R10 route flag off");
    wr(12'h4A0, 32'h8000_0007);
    tick(2);
    pinchk('0, 3'd0, "R12 pin index beyond range");
    wr(12'h4A0, 32'hFFFF_FFC1);
    rdchk(12'h4A0, 32'h8000_0001, "R10 route readback");
    tick(2);
    pinchk(6'b000010, 3'd2, "R10 R11 pin 1");
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_level();
    t_edge();
    t_dual();
    t_inject();
    t_mask();
    t_route();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule